// File: doc/BRIEF.md
# TLB Management Register Interface

This block is the software-facing control port of a small translation table. Software selects an entry through an index register, then reads or writes that entry's tag word and data word through two window addresses. The block also holds the current process ID and a zone protection word, and it offers a search address that looks up a virtual page in the table and leaves the result in the index register.

Side effects are carried out by the block. A tag write records the current process ID in the entry and announces that the old mapping is gone. A process-ID change walks the table and announces every mapping owned by the outgoing process. A zone word change requests a full flush. Two parameters give the level of MMU support and the kind of table access allowed, and they gate every access.

Register accesses use a request strobe with a write flag. Read data appears one cycle after the request is accepted. A search or a process-ID walk holds `busy_o` high, and requests made while busy are dropped.

Top module: `tlb_reg_if`

## Requirements
- R1: After reset the index, process-ID and zone registers read as zero, every table entry is invalid, and `busy_o`, `rvalid_o`, `inval_o` and `flush_all_o` are low.
- R2: Register numbers on `addr_i` are 0 data window, 1 tag window, 2 process ID, 3 zone word, 4 index, 5 search. A request accepted while `busy_o` is low gives `rvalid_o` and `rdata_o` one cycle later. Addresses 5, 6 and 7 read as zero.
- R3: Address bit 0 selects the tag window (1) or the data window (0) of the entry picked by the low index bits. Tag layout: page number in bits 31:10, size code in bits 9:7 (page of 1 KiB shifted left by twice the code), valid in bit 6. Data layout: zone number in bits 7:4.
- R4: A tag write stores bits 7:0 of the process ID as the entry's owner ID. If the entry's previous tag had bit 6 set, `inval_o` pulses for one cycle with `inval_idx_o` equal to the index.
- R5: A tag read also loads the selected entry's owner ID into the process-ID register.
- R6: A search write holds `busy_o` high for exactly one cycle. It matches entries that are valid, whose page number agrees with bits 31:10 of the written value above the page size, and whose owner ID is zero or equal to bits 7:0 of the process ID. On a hit the index register becomes the lowest matching index.
- R7: On a search miss, bit 31 of the index register is set and bits 30:0 keep their value.
- R8: In a search, an entry whose zone has the 2-bit code 0 does not match while `user_i` is high. The code of zone z is held in zone word bits 31-2z down to 30-2z.
- R9: A zone word write pulses `flush_all_o` once when the new value differs from the old one, and not when it is equal.
- R10: A process-ID write with a new value holds `busy_o` for ENTRIES cycles and pulses `inval_o` once for each valid entry whose owner ID is non-zero and equals bits 7:0 of the old process ID. An equal value starts no walk.
- R11: With MMU_LEVEL below 2 or TLB_ACCESS equal to 0, every read returns zero and every write is ignored.
- R12: With TLB_ACCESS at most 1, writes to the process-ID, zone and search registers are ignored. Window, process-ID and zone reads need TLB_ACCESS bit 0 set.
- R13: A request made while `busy_o` is high is dropped and gives no `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register number |
| wdata_i | input | 32 | Write data |
| user_i | input | 1 | Searches run in user mode |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read or write acknowledge, one cycle after acceptance |
| busy_o | output | 1 | Search or process-ID walk in progress |
| inval_o | output | 1 | One-cycle pulse: a mapping is invalidated |
| inval_idx_o | output | 8 | Index of the invalidated mapping |
| flush_all_o | output | 1 | One-cycle pulse: full flush requested |

## Verification
A wrong owner ID is visible one cycle after the next tag read, because that ID returns through the process-ID register. A wrong ID also changes search results and the set of invalidate pulses in a later walk. A walk counter that stops early or skips an entry shows up as a wrong `busy_o` length or a missing `inval_o` pulse within ENTRIES cycles. A corrupted index register shows up at the next index read or window access, one cycle after the request.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WORD_W   = 32;
  localparam int OWNER_W  = 8;
  localparam int PN_LSB   = 10;
  localparam int VALID_B  = 6;
  localparam int SZ_LSB   = 7;
  localparam int SZ_W     = 3;
  localparam int ZONE_LSB = 4;
  localparam int ZONE_W   = 4;
  localparam int MISS_B   = 31;

  typedef enum logic [2:0] {
    RA_DATA   = 3'd0,
    RA_TAG    = 3'd1,
    RA_PID    = 3'd2,
    RA_ZONE   = 3'd3,
    RA_INDEX  = 3'd4,
    RA_SEARCH = 3'd5
  } reg_addr_e;

  function automatic logic [WORD_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    return {WORD_W{1'b1}} << (PN_LSB + 2 * int'(sz));
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   sel_i,
  input  logic               tag_we_i,
  input  logic               data_we_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic [OWNER_W-1:0] owner_i,
  output logic [WORD_W-1:0]  sel_tag_o,
  output logic [WORD_W-1:0]  sel_data_o,
  output logic [OWNER_W-1:0] sel_owner_o,
  output logic [WORD_W-1:0]  tag_o   [ENTRIES],
  output logic [WORD_W-1:0]  data_o  [ENTRIES],
  output logic [OWNER_W-1:0] owner_o [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic hit_sel;
    assign hit_sel = (sel_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_o[g]   <= '0;
        data_o[g]  <= '0;
        owner_o[g] <= '0;
      end else begin
        if (tag_we_i && hit_sel) begin
          tag_o[g]   <= wdata_i;
          owner_o[g] <= owner_i;
        end
        if (data_we_i && hit_sel) data_o[g] <= wdata_i;
      end
    end
  end

  assign sel_tag_o   = tag_o[sel_i];
  assign sel_data_o  = data_o[sel_i];
  assign sel_owner_o = owner_o[sel_i];

  p_one_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tag_we_i && data_we_i));
endmodule

// File: rtl/tlb_search.sv
module tlb_search
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int IDX_W     = 4,
  parameter int NUM_ZONES = 16
) (
  input  logic [WORD_W-1:0]  va_i,
  input  logic [OWNER_W-1:0] pid_i,
  input  logic [WORD_W-1:0]  zone_word_i,
  input  logic               user_i,
  input  logic [WORD_W-1:0]  tag_i   [ENTRIES],
  input  logic [WORD_W-1:0]  data_i  [ENTRIES],
  input  logic [OWNER_W-1:0] owner_i [ENTRIES],
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam bit ZONES_FULL = NUM_ZONES >= (1 << ZONE_W);

  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [WORD_W-1:0] msk;
    logic [ZONE_W-1:0] zsel;
    logic [4:0]        zbit;
    logic [1:0]        zcode;
    logic              pg_ok, own_ok, zone_ok;

    assign msk    = page_mask(tag_i[g][SZ_LSB +: SZ_W]);
    assign zsel   = data_i[g][ZONE_LSB +: ZONE_W];
    assign zbit   = 5'd31 - {zsel, 1'b0};
    // zones past the configured count fall back to plain checked access
    assign zcode  = (!ZONES_FULL && (32'(zsel) >= NUM_ZONES)) ? 2'd1
                                                             : zone_word_i[zbit -: 2];
    assign pg_ok  = ((va_i ^ tag_i[g]) & msk) == '0;
    assign own_ok = (owner_i[g] == '0) || (owner_i[g] == pid_i);
    assign zone_ok = !(zcode == 2'd0 && user_i);
    assign match[g] = tag_i[g][VALID_B] && pg_ok && own_ok && zone_ok;
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_pid_walk.sv
module tlb_pid_walk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [OWNER_W-1:0] old_pid_i,
  input  logic [WORD_W-1:0]  tag_i   [ENTRIES],
  input  logic [OWNER_W-1:0] owner_i [ENTRIES],
  output logic               busy_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o
);
  logic               act_q;
  logic [IDX_W-1:0]   cnt_q;
  logic [OWNER_W-1:0] pid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      pid_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
      pid_q <= old_pid_i;
    end else if (act_q) begin
      if (cnt_q == IDX_W'(ENTRIES - 1)) act_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o    = act_q;
  assign hit_idx_o = cnt_q;
  assign hit_o     = act_q && tag_i[cnt_q][VALID_B] &&
                     (owner_i[cnt_q] != '0) && (owner_i[cnt_q] == pid_q);

  p_start_when_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !act_q);
  p_walk_starts_at_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> act_q && cnt_q == '0);
endmodule

// File: rtl/tlb_reg_if.sv
module tlb_reg_if
  import tlb_pkg::*;
#(
  parameter int MMU_LEVEL  = 3,
  parameter int TLB_ACCESS = 3,
  parameter int ENTRIES    = 16,
  parameter int NUM_ZONES  = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        user_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic        busy_o,
  output logic        inval_o,
  output logic [7:0]  inval_idx_o,
  output logic        flush_all_o
);
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam bit BASE_OK = (MMU_LEVEL >= 2) && (TLB_ACCESS != 0);
  localparam bit RD_OK   = BASE_OK && ((TLB_ACCESS % 2) == 1);
  localparam bit WR_OK   = BASE_OK && (TLB_ACCESS > 1);
  localparam logic [WORD_W-1:0] PN_MASK = {{(WORD_W-PN_LSB){1'b1}}, {PN_LSB{1'b0}}};

  logic [WORD_W-1:0] idx_q, pid_q, zone_q, srch_va_q;
  logic              srch_pend_q;

  logic [WORD_W-1:0]  tag_a   [ENTRIES];
  logic [WORD_W-1:0]  data_a  [ENTRIES];
  logic [OWNER_W-1:0] owner_a [ENTRIES];
  logic [WORD_W-1:0]  sel_tag, sel_data;
  logic [OWNER_W-1:0] sel_owner;
  logic [IDX_W-1:0]   sel;

  logic s_hit, w_busy, w_hit;
  logic [IDX_W-1:0] s_idx, w_idx;

  logic accept, acc, wr, rd;
  logic tag_we, data_we, idx_we, pid_chg, zone_we, srch_we, tag_rd;
  reg_addr_e ra;

  assign ra     = reg_addr_e'(addr_i);
  assign busy_o = srch_pend_q | w_busy;
  assign accept = req_i && !busy_o;
  assign acc    = accept && BASE_OK;
  assign wr     = acc && we_i;
  assign rd     = acc && !we_i;
  assign sel    = idx_q[IDX_W-1:0];

  assign tag_we  = wr && ra == RA_TAG;
  assign data_we = wr && ra == RA_DATA;
  assign idx_we  = wr && ra == RA_INDEX;
  assign pid_chg = wr && WR_OK && ra == RA_PID && wdata_i != pid_q;
  assign zone_we = wr && WR_OK && ra == RA_ZONE;
  assign srch_we = wr && WR_OK && ra == RA_SEARCH;
  assign tag_rd  = rd && RD_OK && ra == RA_TAG;

  tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .tag_we_i    (tag_we),
    .data_we_i   (data_we),
    .wdata_i     (wdata_i),
    .owner_i     (pid_q[OWNER_W-1:0]),
    .sel_tag_o   (sel_tag),
    .sel_data_o  (sel_data),
    .sel_owner_o (sel_owner),
    .tag_o       (tag_a),
    .data_o      (data_a),
    .owner_o     (owner_a)
  );

  tlb_search #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .NUM_ZONES(NUM_ZONES)) i_search (
    .va_i        (srch_va_q),
    .pid_i       (pid_q[OWNER_W-1:0]),
    .zone_word_i (zone_q),
    .user_i      (user_i),
    .tag_i       (tag_a),
    .data_i      (data_a),
    .owner_i     (owner_a),
    .hit_o       (s_hit),
    .idx_o       (s_idx)
  );

  tlb_pid_walk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (pid_chg),
    .old_pid_i (pid_q[OWNER_W-1:0]),
    .tag_i     (tag_a),
    .owner_i   (owner_a),
    .busy_o    (w_busy),
    .hit_o     (w_hit),
    .hit_idx_o (w_idx)
  );

  // architectural registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      pid_q       <= '0;
      zone_q      <= '0;
      srch_va_q   <= '0;
      srch_pend_q <= 1'b0;
    end else begin
      srch_pend_q <= srch_we;
      if (srch_we) srch_va_q <= wdata_i & PN_MASK;
      if (idx_we) idx_q <= wdata_i;
      else if (srch_pend_q) begin
        if (s_hit) idx_q <= WORD_W'(s_idx);
        else       idx_q[MISS_B] <= 1'b1;
      end
      if (pid_chg)     pid_q <= wdata_i;
      else if (tag_rd) pid_q <= WORD_W'(sel_owner);
      if (zone_we) zone_q <= wdata_i;
    end
  end

  // read path and event pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      rvalid_o    <= 1'b0;
      inval_o     <= 1'b0;
      inval_idx_o <= '0;
      flush_all_o <= 1'b0;
    end else begin
      rvalid_o <= accept;
      rdata_o  <= '0;
      if (rd) begin
        unique case (ra)
          RA_DATA:  rdata_o <= RD_OK ? sel_data : '0;
          RA_TAG:   rdata_o <= RD_OK ? sel_tag  : '0;
          RA_PID:   rdata_o <= RD_OK ? pid_q    : '0;
          RA_ZONE:  rdata_o <= RD_OK ? zone_q   : '0;
          RA_INDEX: rdata_o <= idx_q;
          default:  rdata_o <= '0;
        endcase
      end
      inval_o     <= (tag_we && sel_tag[VALID_B]) || w_hit;
      inval_idx_o <= w_hit ? 8'(w_idx) : 8'(sel);
      flush_all_o <= zone_we && (wdata_i != zone_q);
    end
  end

  p_busy_drops_req_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o) |=> !rvalid_o);
  p_read_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !we_i) |=> rvalid_o);
  p_search_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srch_pend_q) |=> !srch_pend_q);
  p_hit_loads_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_pend_q && s_hit) |=> idx_q == WORD_W'($past(s_idx)));
  p_miss_keeps_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_pend_q && !s_hit) |=> idx_q[MISS_B] && idx_q[30:0] == $past(idx_q[30:0]));
  p_same_zone_no_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zone_we && wdata_i == zone_q) |=> !flush_all_o);
  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(srch_pend_q && w_busy));
endmodule

// File: tb/test_tlb_reg_if.sv
module test_tlb_reg_if;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  req = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        user = 1'b0;

  logic [31:0] rdata [3];
  logic [2:0]  rvalid, busy, inval, flush;
  logic [7:0]  inval_idx [3];

  int n_chk = 0, n_err = 0;
  int inval_cnt = 0, flush_cnt[3] = '{0, 0, 0};
  logic [7:0] last_inval = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_reg_if #(.ENTRIES(N_ENT)) i_tlb_reg_if (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[0]), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .user_i(user), .rdata_o(rdata[0]), .rvalid_o(rvalid[0]),
    .busy_o(busy[0]), .inval_o(inval[0]), .inval_idx_o(inval_idx[0]),
    .flush_all_o(flush[0]));

  tlb_reg_if #(.MMU_LEVEL(1), .ENTRIES(N_ENT)) i_tlb_reg_if_nommu (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[1]), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .user_i(user), .rdata_o(rdata[1]), .rvalid_o(rvalid[1]),
    .busy_o(busy[1]), .inval_o(inval[1]), .inval_idx_o(inval_idx[1]),
    .flush_all_o(flush[1]));

  tlb_reg_if #(.TLB_ACCESS(1), .ENTRIES(N_ENT)) i_tlb_reg_if_rdonly (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[2]), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .user_i(user), .rdata_o(rdata[2]), .rvalid_o(rvalid[2]),
    .busy_o(busy[2]), .inval_o(inval[2]), .inval_idx_o(inval_idx[2]),
    .flush_all_o(flush[2]));

  always @(negedge clk) begin
    if (inval[0]) begin
      inval_cnt++;
      last_inval = inval_idx[0];
    end
    for (int k = 0; k < 3; k++) if (flush[k]) flush_cnt[k]++;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  logic [31:0] rd_v;
  logic        rv_v;
  int          bc_v;

  task automatic acc(input int s, input bit w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    while (busy[s]) @(negedge clk);
    req[s] = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req[s] = 1'b0;
    rd_v = rdata[s];
    rv_v = rvalid[s];
    bc_v = 0;
    while (busy[s]) begin
      bc_v++;
      @(negedge clk);
    end
  endtask

  task automatic rchk(input int s, input logic [2:0] a, input logic [31:0] exp, input string rq);
    acc(s, 1'b0, a, 32'h0);
    chk(rq, {31'b0, rv_v}, 32'h1);
    chk(rq, rd_v, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic        w;
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  rq;
  } vec_t;

  // register walk on the default instance; rq holds the requirement number
  localparam vec_t VECS [15] = '{
    '{1'b1, 3'd4, 32'h0000_0002, 32'h0, 8'd2},   // R2 index
    '{1'b1, 3'd2, 32'h0000_0015, 32'h0, 8'd10},  // R10 pid, empty table
    '{1'b1, 3'd0, 32'h8000_0330, 32'h0, 8'd3},   // R3 data window
    '{1'b1, 3'd1, 32'h0040_0040, 32'h0, 8'd4},   // R4 tag window, old invalid
    '{1'b0, 3'd1, 32'h0, 32'h0040_0040, 8'd3},   // R3
    '{1'b0, 3'd0, 32'h0, 32'h8000_0330, 8'd3},   // R3
    '{1'b1, 3'd2, 32'h0000_0077, 32'h0, 8'd10},  // R10 walk hits entry 2
    '{1'b0, 3'd2, 32'h0, 32'h0000_0077, 8'd2},
    '{1'b0, 3'd1, 32'h0, 32'h0040_0040, 8'd5},   // R5 owner copied back
    '{1'b0, 3'd2, 32'h0, 32'h0000_0015, 8'd5},
    '{1'b1, 3'd3, 32'hC000_0000, 32'h0, 8'd9},   // R9
    '{1'b0, 3'd3, 32'h0, 32'hC000_0000, 8'd2},
    '{1'b0, 3'd4, 32'h0, 32'h0000_0002, 8'd2},
    '{1'b0, 3'd6, 32'h0, 32'h0, 8'd2},           // R2 unmapped
    '{1'b0, 3'd5, 32'h0, 32'h0, 8'd2}            // R2 search reads zero
  };

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {29'b0, busy}, 32'h0);
    chk("R1 rvalid", {29'b0, rvalid}, 32'h0);
    chk("R1 pulses", {26'b0, inval, flush}, 32'h0);
    rst_n = 1'b1;
    rchk(0, 3'd4, 32'h0, "R1 index");
    rchk(0, 3'd2, 32'h0, "R1 pid");
    rchk(0, 3'd3, 32'h0, "R1 zone");
    rchk(0, 3'd1, 32'h0, "R1 tag");

    foreach (VECS[i]) begin
      acc(0, VECS[i].w, VECS[i].a, VECS[i].d);
      if (!VECS[i].w) chk($sformatf("R%0d vec %0d", VECS[i].rq, i), rd_v, VECS[i].e);
    end
    settle();
    chk("R10 walk count", 32'(inval_cnt), 32'd1);
    chk("R10 walk idx", 32'(last_inval), 32'd2);
    chk("R9 flush count", 32'(flush_cnt[0]), 32'd1);

    // R6 hit, busy for one cycle
    acc(0, 1'b1, 3'd5, 32'h0040_03FF);
    chk("R6 busy", 32'(bc_v), 32'd1);
    rchk(0, 3'd4, 32'h0000_0002, "R6 hit");
    // R10 walk length, owner mismatch then R7 miss
    acc(0, 1'b1, 3'd2, 32'h0000_0033);
    chk("R10 busy", 32'(bc_v), 32'(N_ENT));
    settle();
    chk("R10 second walk", 32'(inval_cnt), 32'd2);
    acc(0, 1'b1, 3'd5, 32'h0040_0000);
    rchk(0, 3'd4, 32'h8000_0002, "R7 miss owner");
    acc(0, 1'b1, 3'd4, 32'h0000_0005);
    acc(0, 1'b1, 3'd5, 32'h0040_0000);
    rchk(0, 3'd4, 32'h8000_0005, "R7 miss keeps low");
    // global entry (owner 0), zero old pid walks hit nothing
    acc(0, 1'b1, 3'd2, 32'h0);
    acc(0, 1'b1, 3'd4, 32'd6);
    acc(0, 1'b1, 3'd0, 32'h0000_0010);
    acc(0, 1'b1, 3'd1, 32'h0080_0040);
    acc(0, 1'b1, 3'd2, 32'h0000_0044);
    settle();
    chk("R10 no owner match", 32'(inval_cnt), 32'd2);
    acc(0, 1'b1, 3'd5, 32'h0080_0000);
    rchk(0, 3'd4, 32'd6, "R6 global owner");
    // 16 KiB entry at index 3: size and priority
    acc(0, 1'b1, 3'd4, 32'd3);
    acc(0, 1'b1, 3'd0, 32'h0);
    acc(0, 1'b1, 3'd1, 32'h0080_0140);
    acc(0, 1'b1, 3'd5, 32'h0080_3000);
    rchk(0, 3'd4, 32'd3, "R6 large page");
    acc(0, 1'b1, 3'd5, 32'h0080_0000);
    rchk(0, 3'd4, 32'd3, "R6 lowest index");
    acc(0, 1'b1, 3'd5, 32'h0080_7000);
    rchk(0, 3'd4, 32'h8000_0003, "R6 page bound");
    // R9 equal value, R8 zone code 0 in user mode
    acc(0, 1'b1, 3'd3, 32'hC000_0000);
    acc(0, 1'b1, 3'd3, 32'h0);
    settle();
    chk("R9 equal no flush", 32'(flush_cnt[0]), 32'd2);
    acc(0, 1'b1, 3'd4, 32'd0);
    user = 1'b1;
    acc(0, 1'b1, 3'd5, 32'h0080_3000);
    rchk(0, 3'd4, 32'h8000_0000, "R8 user blocked");
    user = 1'b0;
    acc(0, 1'b1, 3'd5, 32'h0080_3000);
    rchk(0, 3'd4, 32'd3, "R8 kernel allowed");
    acc(0, 1'b1, 3'd3, 32'h4000_0000);
    user = 1'b1;
    acc(0, 1'b1, 3'd4, 32'd0);
    acc(0, 1'b1, 3'd5, 32'h0080_3000);
    rchk(0, 3'd4, 32'd3, "R8 user code 1");
    user = 1'b0;
    // R4 overwrite of a valid tag
    acc(0, 1'b1, 3'd4, 32'd3);
    acc(0, 1'b1, 3'd1, 32'h00C0_0040);
    settle();
    chk("R4 inval count", 32'(inval_cnt), 32'd3);
    chk("R4 inval idx", 32'(last_inval), 32'd3);
    rchk(0, 3'd1, 32'h00C0_0040, "R3 tag");

    // R13 request during a walk is dropped
    @(negedge clk);
    req[0] = 1'b1; we = 1'b1; addr = 3'd2; wdata = 32'h99;
    @(negedge clk);
    we = 1'b0; addr = 3'd4;
    chk("R13 busy", {31'b0, busy[0]}, 32'h1);
    @(negedge clk);
    req[0] = 1'b0;
    chk("R13 no rvalid", {31'b0, rvalid[0]}, 32'h0);
    while (busy[0]) @(negedge clk);

    // R11 no MMU support
    acc(1, 1'b1, 3'd4, 32'd7);
    rchk(1, 3'd4, 32'h0, "R11 index");
    acc(1, 1'b1, 3'd3, 32'd5);
    settle();
    chk("R11 no flush", 32'(flush_cnt[1]), 32'd0);
    // R12 read-only control access
    acc(2, 1'b1, 3'd2, 32'h55);
    rchk(2, 3'd2, 32'h0, "R12 pid");
    acc(2, 1'b1, 3'd3, 32'd5);
    rchk(2, 3'd3, 32'h0, "R12 zone");
    acc(2, 1'b1, 3'd4, 32'd4);
    acc(2, 1'b1, 3'd5, 32'h0);
    chk("R12 search no busy", 32'(bc_v), 32'd0);
    rchk(2, 3'd4, 32'd4, "R12 search ignored");
    acc(2, 1'b1, 3'd1, 32'h40);
    rchk(2, 3'd1, 32'h40, "R12 tag read");
    settle();
    chk("R12 no flush", 32'(flush_cnt[2]), 32'd0);
    report();
  end
endmodule